// File: doc/BRIEF.md
# SDRAM Mode-Register Programming Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM and writes the device's two mode registers from a small request. A request carries a burst length, a CAS latency, a DLL on/off choice, a drive-strength choice and the data-width organisation of the attached device. After a `start` pulse the sequencer checks the request and waits until the bank-state logic reports every bank idle. It then issues a LOAD MODE REGISTER command to the extended register, waits a fixed spacing, and issues a second one to the base register. When the DLL is being switched on, that base write carries the DLL-reset bit.

The command pins are registered and change only on the rising clock edge. NOP is driven on every cycle that does not carry a mode-register write. A `read_ok` flag goes low when the extended register is written. It goes high again only after a DLL settle interval, counted from the DLL-reset write. The read scheduler uses this flag to gate READ commands. Requests that the device cannot accept are refused at once: no command is issued, and `done` and `err` pulse together.

Top module: `mrs_seq`

## Requirements
- R1: While reset is asserted and directly after it: the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), ba and addr are zero, and busy, done, err and read_ok are low.
- R2: A request is refused when any of these holds: burst length is not 2, 4 or 8; the CAS code is 2 or 3 (code 0 means CL 2, code 1 means CL 2.5); the organisation code is 3 (codes 0=x4, 1=x8, 2=x16); reduced drive is asked for with an organisation other than x16. On a refusal, done and err are high for exactly the one cycle after the start edge, busy stays low and no command is issued.
- R3: The first command of an accepted request is LOAD MODE REGISTER (cs_n, ras_n, cas_n, we_n all 0) with ba=1. In it, addr bit 0 is 1 when the DLL is off, addr bit 1 is 1 for reduced drive, and every other addr bit is 0. It is issued on the first edge after the start edge at which banks_idle is high.
- R4: The second command is LOAD MODE REGISTER with ba=0. Its addr bits 2:0 carry the burst code (001 for 2, 010 for 4, 011 for 8). Bits 6:4 carry 010 for CL 2 or 110 for CL 2.5. Bit 8 (DLL reset) is 1 exactly when the DLL is being enabled. All other bits are 0.
- R5: The base write follows the extended write by at least T_MRD clock edges, and by exactly T_MRD when banks_idle stays high. Every cycle without a mode-register write shows NOP with ba and addr zero.
- R6: No mode-register write is issued on an edge at which banks_idle is low; the sequence waits instead.
- R7: busy is high from the start edge until done. done pulses for one cycle exactly T_MRD edges after the base write, with err low, and busy falls on that same edge.
- R8: A start pulse while busy is high is ignored: the commands issued still match the request accepted first.
- R9: read_ok goes low on the extended-register write. If the DLL was enabled, read_ok rises exactly DLL_SETTLE edges after the base write. If the DLL was disabled, read_ok stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| req_bl | input | BL_W | Requested burst length as a plain number |
| req_cl | input | 2 | CAS latency code: 0 = 2, 1 = 2.5 |
| req_org | input | 2 | Device organisation: 0 = x4, 1 = x8, 2 = x16 |
| req_dll_on | input | 1 | 1 to enable the DLL, 0 to disable it |
| req_drv_low | input | 1 | 1 to select reduced output drive |
| banks_idle | input | 1 | All four banks idle and no burst running |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, selects the register |
| addr | output | ADDR_W | Address bus, carries the register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refusal flag, pulses with done |
| read_ok | output | 1 | READ commands permitted |

## Verification
Directed requests cover each refusal rule on its own: an odd burst length, a bad CAS code, the reserved organisation code, and reduced drive on x8 and on x4. These show that each rule alone blocks the command bus. Accepted requests sweep every burst length, both latencies, both DLL choices and both drive strengths, so that each field is shown to land on its own address bits. Holding banks_idle low before the first write and during the spacing window separates the idle wait from the fixed spacing. A DLL-on run followed by a DLL-off run shows that read_ok tracks the settle interval and is not left high. Randomised mixes of these fields, with stray start pulses during a sequence, are compared against encodings computed in the bench.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EMR,
      ST_MR,
      ST_TAIL
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

   localparam logic [1:0] ORG_X4  = 2'd0;
   localparam logic [1:0] ORG_X8  = 2'd1;
   localparam logic [1:0] ORG_X16 = 2'd2;

   localparam logic [1:0] CL_TWO      = 2'd0;
   localparam logic [1:0] CL_TWO_HALF = 2'd1;

   localparam int unsigned EXT_DLL_BIT = 0;
   localparam int unsigned EXT_DRV_BIT = 1;
   localparam int unsigned BASE_RST_BIT = 8;

endpackage

// File: rtl/mrs_word_build.sv
module mrs_word_build
   import mrs_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BL_W   = 4
) (
   input  logic [BL_W-1:0]   req_bl,
   input  logic [1:0]        req_cl,
   input  logic [1:0]        req_org,
   input  logic              req_dll_on,
   input  logic              req_drv_low,
   output logic              req_ok,
   output logic [ADDR_W-1:0] ext_word,
   output logic [ADDR_W-1:0] base_word
);

   localparam int unsigned MIN_ADDR_W = BASE_RST_BIT + 1;

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
         $error("mrs_word_build: ADDR_W too small for the DLL reset bit");
      end
      if (BL_W < 4) begin : g_bad_bl_w
         $error("mrs_word_build: BL_W must hold the value 8");
      end
   endgenerate

   logic [2:0] bl_code;
   logic [2:0] cl_code;
   logic       bl_ok;
   logic       cl_ok;
   logic       org_ok;
   logic       drv_ok;

   always_comb begin
      bl_ok   = 1'b1;
      bl_code = 3'b000;
      if (req_bl == BL_W'(2)) begin
         bl_code = 3'b001;
      end else if (req_bl == BL_W'(4)) begin
         bl_code = 3'b010;
      end else if (req_bl == BL_W'(8)) begin
         bl_code = 3'b011;
      end else begin
         bl_ok = 1'b0;
      end
   end

   always_comb begin
      cl_ok = 1'b1;
      case (req_cl)
         CL_TWO:      cl_code = 3'b010;
         CL_TWO_HALF: cl_code = 3'b110;
         default: begin
            cl_code = 3'b000;
            cl_ok   = 1'b0;
         end
      endcase
   end

   always_comb begin
      org_ok = (req_org == ORG_X4) || (req_org == ORG_X8) || (req_org == ORG_X16);
      drv_ok = !req_drv_low || (req_org == ORG_X16);
      req_ok = bl_ok && cl_ok && org_ok && drv_ok;
   end

   always_comb begin
      ext_word              = '0;
      ext_word[EXT_DLL_BIT] = ~req_dll_on;
      ext_word[EXT_DRV_BIT] = req_drv_low;
   end

   always_comb begin
      base_word               = '0;
      base_word[2:0]          = bl_code;
      base_word[6:4]          = cl_code;
      base_word[BASE_RST_BIT] = req_dll_on;
   end

endmodule

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer #(
   parameter int unsigned GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   localparam int unsigned CW = $clog2(GAP) + 1;
   localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

   generate
      if (GAP < 2) begin : g_bad_gap
         $error("mrs_gap_timer: GAP must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= RELOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

   // R5: the sequencer never starts a new spacing window early
   a_r5_load_after_expiry: assert property (
      @(posedge clk) disable iff (!rst_n) load |-> expired
   );

endmodule

// File: rtl/mrs_dll_guard.sv
module mrs_dll_guard #(
   parameter int unsigned SETTLE = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic arm,
   output logic read_ok
);

   localparam int unsigned CW = $clog2(SETTLE) + 1;
   localparam logic [CW-1:0] RELOAD = CW'(SETTLE - 1);

   generate
      if (SETTLE < 1) begin : g_bad_settle
         $error("mrs_dll_guard: SETTLE must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          armed;
   logic          ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         ok_q  <= 1'b0;
      end else if (kill) begin
         cnt   <= '0;
         armed <= 1'b0;
         ok_q  <= 1'b0;
      end else if (arm) begin
         cnt   <= RELOAD;
         armed <= 1'b1;
         ok_q  <= 1'b0;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else if (armed) begin
         ok_q <= 1'b1;
      end
   end

   assign read_ok = ok_q;

   // R9: read permission only ever appears after an arming write
   a_r9_ok_needs_arm: assert property (
      @(posedge clk) disable iff (!rst_n) $rose(ok_q) |-> $past(armed)
   );

endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
   import mrs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned BA_W       = 2,
   parameter int unsigned BL_W       = 4,
   parameter int unsigned T_MRD      = 2,
   parameter int unsigned DLL_SETTLE = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BL_W-1:0]   req_bl,
   input  logic [1:0]        req_cl,
   input  logic [1:0]        req_org,
   input  logic              req_dll_on,
   input  logic              req_drv_low,
   input  logic              banks_idle,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              read_ok
);

   localparam logic [BA_W-1:0] BA_BASE = '0;
   localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);

   generate
      if (BA_W < 2) begin : g_bad_ba_w
         $error("mrs_seq: BA_W must be at least 2");
      end
      if (DLL_SETTLE <= T_MRD) begin : g_bad_settle
         $error("mrs_seq: DLL_SETTLE must exceed T_MRD");
      end
   endgenerate

   seq_state_e        st;
   cmd_pins_t         cmd_q;
   logic [BA_W-1:0]   ba_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] ext_q;
   logic [ADDR_W-1:0] base_q;
   logic              busy_q;
   logic              done_q;
   logic              err_q;

   logic              req_ok;
   logic [ADDR_W-1:0] ext_word;
   logic [ADDR_W-1:0] base_word;
   logic              gap_done;
   logic              issue_ext;
   logic              issue_base;
   logic              gap_load;
   logic              dll_arm;

   mrs_word_build #(
      .ADDR_W (ADDR_W),
      .BL_W   (BL_W)
   ) u_build (
      .req_bl      (req_bl),
      .req_cl      (req_cl),
      .req_org     (req_org),
      .req_dll_on  (req_dll_on),
      .req_drv_low (req_drv_low),
      .req_ok      (req_ok),
      .ext_word    (ext_word),
      .base_word   (base_word)
   );

   always_comb begin
      issue_ext  = (st == ST_EMR) && banks_idle;
      issue_base = (st == ST_MR) && banks_idle && gap_done;
      gap_load   = issue_ext || issue_base;
      dll_arm    = issue_base && base_q[BASE_RST_BIT];
   end

   mrs_gap_timer #(
      .GAP (T_MRD)
   ) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gap_load),
      .expired (gap_done)
   );

   mrs_dll_guard #(
      .SETTLE (DLL_SETTLE)
   ) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (issue_ext),
      .arm     (dll_arm),
      .read_ok (read_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         ext_q  <= '0;
         base_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  if (req_ok) begin
                     ext_q  <= ext_word;
                     base_q <= base_word;
                     busy_q <= 1'b1;
                     st     <= ST_EMR;
                  end else begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end
               end
            end
            ST_EMR: begin
               if (issue_ext) begin
                  cmd_q  <= CMD_LMR;
                  ba_q   <= BA_EXT;
                  addr_q <= ext_q;
                  st     <= ST_MR;
               end
            end
            ST_MR: begin
               if (issue_base) begin
                  cmd_q  <= CMD_LMR;
                  ba_q   <= BA_BASE;
                  addr_q <= base_q;
                  st     <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (gap_done) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cs_n  = cmd_q.cs_n;
   assign ras_n = cmd_q.ras_n;
   assign cas_n = cmd_q.cas_n;
   assign we_n  = cmd_q.we_n;
   assign ba    = ba_q;
   assign addr  = addr_q;
   assign busy  = busy_q;
   assign done  = done_q;
   assign err   = err_q;

   // Observation of the command bus for the checks below
   logic lmr_seen;
   logic reset_owed;

   assign lmr_seen = !cs_n && !ras_n && !cas_n && !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_owed <= 1'b0;
      end else if (lmr_seen && (ba == BA_EXT) && !addr[EXT_DLL_BIT]) begin
         reset_owed <= 1'b1;
      end else if (lmr_seen && (ba == BA_BASE)) begin
         reset_owed <= 1'b0;
      end
   end

   // R6: a mode-register write appears only after an idle sample
   a_r6_write_needs_idle: assert property (
      @(posedge clk) disable iff (!rst_n) lmr_seen |-> $past(banks_idle)
   );

   // R3: reserved bits of the extended register stay clear
   a_r3_ext_reserved_zero: assert property (
      @(posedge clk) disable iff (!rst_n)
      (lmr_seen && ba == BA_EXT) |-> (addr[ADDR_W-1:2] == '0)
   );

   // R4: DLL enable is followed by a base write with DLL reset
   a_r4_reset_after_enable: assert property (
      @(posedge clk) disable iff (!rst_n)
      (lmr_seen && reset_owed) |-> (ba == BA_BASE && addr[BASE_RST_BIT])
   );

   // R9: reads are never permitted while a register is being rewritten
   a_r9_reads_blocked: assert property (
      @(posedge clk) disable iff (!rst_n) lmr_seen |-> !read_ok
   );

   // R7: completion and activity never overlap
   a_r7_done_not_busy: assert property (
      @(posedge clk) disable iff (!rst_n) done |-> !busy
   );

   // R2: an error is always reported as a completion
   a_r2_err_with_done: assert property (
      @(posedge clk) disable iff (!rst_n) err |-> done
   );

endmodule

// File: tb/tb_mrs_seq.sv
module tb_mrs_seq;

   localparam int unsigned ADDR_W = 13;
   localparam int unsigned BA_W   = 2;
   localparam int unsigned BL_W   = 4;
   localparam int          T_MRD  = 2;
   localparam int          SETTLE = 200;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [BL_W-1:0]   req_bl = '0;
   logic [1:0]        req_cl = '0;
   logic [1:0]        req_org = '0;
   logic              req_dll_on = 1'b0;
   logic              req_drv_low = 1'b0;
   logic              banks_idle = 1'b0;
   logic              cs_n, ras_n, cas_n, we_n;
   logic [BA_W-1:0]   ba;
   logic [ADDR_W-1:0] addr;
   logic              busy, done, err, read_ok;

   int n_chk = 0;
   int n_fail = 0;
   logic prev_rok = 1'b0;

   always #4 clk = ~clk;

   mrs_seq #(
      .ADDR_W     (ADDR_W),
      .BA_W       (BA_W),
      .BL_W       (BL_W),
      .T_MRD      (T_MRD),
      .DLL_SETTLE (SETTLE)
   ) dut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .req_bl (req_bl), .req_cl (req_cl), .req_org (req_org),
      .req_dll_on (req_dll_on), .req_drv_low (req_drv_low),
      .banks_idle (banks_idle),
      .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .ba (ba), .addr (addr), .busy (busy), .done (done), .err (err),
      .read_ok (read_ok)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit req_legal(input logic [3:0] bl, input logic [1:0] cl,
                                    input logic [1:0] org, input logic drv);
      bit ok = 1'b1;
      if (!(bl == 4'd2 || bl == 4'd4 || bl == 4'd8)) ok = 1'b0;
      if (cl > 2'd1) ok = 1'b0;
      if (org == 2'd3) ok = 1'b0;
      if (drv && org != 2'd2) ok = 1'b0;
      return ok;
   endfunction

   function automatic logic [12:0] exp_ext(input logic dll, input logic drv);
      logic [12:0] w = '0;
      w[0] = ~dll;
      w[1] = drv;
      return w;
   endfunction

   function automatic logic [12:0] exp_base(input logic [3:0] bl, input logic [1:0] cl,
                                            input logic dll);
      logic [12:0] w = '0;
      w[2:0] = (bl == 4'd2) ? 3'b001 : (bl == 4'd4) ? 3'b010 : 3'b011;
      w[6:4] = (cl == 2'd0) ? 3'b010 : 3'b110;
      w[8]   = dll;
      return w;
   endfunction

   function automatic logic [3:0] cmd_bits();
      return {cs_n, ras_n, cas_n, we_n};
   endfunction

   task automatic do_prog(input logic [3:0] bl, input logic [1:0] cl, input logic [1:0] org,
                          input logic dll, input logic drv, input int idle_gap,
                          input int mr_stall, input bit poke);
      bit ok = req_legal(bl, cl, org, drv);
      logic [12:0] ew = exp_ext(dll, drv);
      logic [12:0] mw = exp_base(bl, cl, dll);
      int ke = (idle_gap > 1) ? idle_gap : 1;
      int km = ke + T_MRD + mr_stall;
      int kd = km + T_MRD + 1;
      int kend = dll ? km + SETTLE + 1 : kd + 2;
      @(negedge clk);
      req_bl = bl; req_cl = cl; req_org = org; req_dll_on = dll; req_drv_low = drv;
      start = 1'b1;
      banks_idle = (idle_gap == 0);
      if (!ok) begin
         @(negedge clk);
         start = 1'b0;
         banks_idle = 1'b1;
         chk("R2 done on refusal", 32'(done), 32'd1);
         chk("R2 err on refusal", 32'(err), 32'd1);
         chk("R2 busy stays low", 32'(busy), 32'd0);
         chk("R2 no command", 32'(cmd_bits()), 32'hF & 32'b0111);
         @(negedge clk);
         chk("R2 done one cycle", 32'({done, err, busy}), 32'd0);
         chk("R2 no command later", 32'(cmd_bits()), 32'b0111);
         chk("R9 read_ok unchanged by refusal", 32'(read_ok), 32'(prev_rok));
         return;
      end
      for (int k = 1; k <= kend; k++) begin
         @(negedge clk);
         start = poke && (k == 2);
         if (poke && k == 2) begin
            req_bl = 4'd2; req_cl = ~cl; req_dll_on = ~dll; req_drv_low = 1'b0;
         end
         banks_idle = (k >= idle_gap) && !(k > ke && k < ke + T_MRD + mr_stall);
         if (k - 1 == ke) begin
            chk("R3 ext write command", 32'(cmd_bits()), 32'd0);
            chk("R3 ext bank select", 32'(ba), 32'd1);
            chk("R3 ext value", 32'(addr), 32'(ew));
         end else if (k - 1 == km) begin
            chk("R4 base write command", 32'(cmd_bits()), 32'd0);
            chk("R4 base bank select", 32'(ba), 32'd0);
            chk(poke ? "R8 base value after stray start" : "R4 base value",
                32'(addr), 32'(mw));
         end else begin
            chk("R5 R6 NOP between writes", 32'({cmd_bits(), ba, addr}),
                32'({4'b0111, 2'b00, 13'd0}));
         end
         if (k <= kd + 1) begin
            chk("R7 busy window", 32'(busy), 32'(k < kd));
            chk("R7 done pulse", 32'(done), 32'(k == kd));
            chk("R7 err low", 32'(err), 32'd0);
         end
         if (k - 1 < ke)
            chk("R9 read_ok before ext write", 32'(read_ok), 32'(prev_rok));
         else
            chk("R9 read_ok settle", 32'(read_ok), 32'(dll && (k - 1 >= km + SETTLE)));
      end
      prev_rok = dll;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 command in reset", 32'({cmd_bits(), ba, addr}), 32'({4'b0111, 2'b00, 13'd0}));
      chk("R1 flags in reset", 32'({busy, done, err, read_ok}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 command after reset", 32'({cmd_bits(), ba, addr}), 32'({4'b0111, 2'b00, 13'd0}));
      chk("R1 flags after reset", 32'({busy, done, err, read_ok}), 32'd0);

      // refusals, one rule each
      do_prog(4'd3, 2'd0, 2'd2, 1'b1, 1'b0, 0, 0, 0);
      do_prog(4'd16 - 4'd1, 2'd0, 2'd2, 1'b1, 1'b0, 0, 0, 0);
      do_prog(4'd4, 2'd2, 2'd2, 1'b1, 1'b0, 0, 0, 0);
      do_prog(4'd4, 2'd3, 2'd0, 1'b1, 1'b0, 0, 0, 0);
      do_prog(4'd8, 2'd0, 2'd3, 1'b0, 1'b0, 0, 0, 0);
      do_prog(4'd8, 2'd1, 2'd1, 1'b1, 1'b1, 0, 0, 0);
      do_prog(4'd2, 2'd1, 2'd0, 1'b1, 1'b1, 0, 0, 0);

      // accepted requests
      do_prog(4'd8, 2'd1, 2'd2, 1'b1, 1'b1, 0, 0, 0);
      do_prog(4'd2, 2'd0, 2'd0, 1'b0, 1'b0, 0, 0, 0);
      do_prog(4'd4, 2'd0, 2'd1, 1'b1, 1'b0, 3, 2, 0);
      do_prog(4'd4, 2'd1, 2'd2, 1'b0, 1'b1, 2, 1, 1);
      do_prog(4'd2, 2'd1, 2'd2, 1'b1, 1'b0, 0, 0, 1);
      // refusal while read_ok is high leaves it high
      do_prog(4'd5, 2'd0, 2'd2, 1'b1, 1'b0, 0, 0, 0);

      for (int i = 0; i < 30; i++) begin
         int pick = $urandom_range(0, 9);
         logic [3:0] bl = (pick < 3) ? 4'd2 : (pick < 6) ? 4'd4 : (pick < 9) ? 4'd8 : 4'($urandom_range(0, 15));
         logic [1:0] cl = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
         logic [1:0] org = 2'($urandom_range(0, 3));
         logic dll = 1'($urandom_range(0, 1));
         logic drv = ($urandom_range(0, 3) == 0);
         do_prog(bl, cl, org, dll, drv, $urandom_range(0, 3), $urandom_range(0, 2),
                 bit'($urandom_range(0, 1)));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule